// File: doc/BRIEF.md
# Indirect Statistics Counter Access Unit

This unit keeps a bank of per-port statistics counters and a small group of counters for packets dropped across all ports. The packet datapath raises an increment strobe together with a counter index. Software never reads a counter directly. It goes through a byte-wide register window instead. It first writes a function code that names the counter group, then writes the counter index, which starts the fetch. After a fixed delay it reads a 32-bit result one byte at a time.

The two top bits of the result carry status. Bit 30 tells software whether the fetch has finished. Bit 31 tells it whether the counter wrapped since it was last cleared. Fetching a per-port counter resets it. Dropped-packet counters keep running and are never reset by a fetch. The fetched word is held as a snapshot until the next fetch replaces it.

Top module: `stat_access_unit`

## Requirements
- R1: After reset, result registers 117 to 120 and registers 110 and 111 all read 0x00.
- R2: A write of index N to register 111 starts a fetch only if register 110 holds 0x1C (per-port group) or 0x1D (dropped-packet group). With any other value in register 110, the write changes neither the result nor any counter.
- R3: Take the clock edge that samples the starting write. From that edge until three edges later, every result byte reads 0x00. From the fourth edge after it, the result holds the fetched word with bit 30 set to 1.
- R4: Register 117 returns result bits 31:24, 118 returns 23:16, 119 returns 15:8 and 120 returns 7:0. Registers 110 and 111 read back the last byte written to them. Every other address reads 0x00.
- R5: A per-port result carries the counter value in bits 29:0, zero-extended from the counter width (30 bits by default). That value counts every per-port strobe for that index sampled on any edge before the capture edge.
- R6: A fetch sets a per-port counter to zero on its capture edge. If a strobe for the same index is sampled on that same edge, the result leaves it out and the counter is left at 1.
- R7: When a per-port counter increments from its all-ones value, it wraps to 0 and sets a sticky flag, reported in result bit 31. A clearing fetch clears the flag together with the counter.
- R8: Dropped-packet counters are 16 bits wide and wrap silently. They are reported in result bits 15:0, with bit 31 and bits 29:16 equal to 0. A fetch does not change them.
- R9: Some fetches name an index outside the group: 160 or above for per-port, 8 or above for dropped-packet. Such a fetch returns 0x40000000. Strobes with an out-of-group index change no counter.
- R10: Once captured, the result does not change when counters increment. A new starting write replaces it. A starting write made while a fetch is pending aborts that fetch, which leaves its counter uncleared, and restarts the delay from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for reg_addr (combinational) |
| cnt_inc | input | 1 | Per-port counter increment strobe |
| cnt_inc_idx | input | 8 | Index of the per-port counter to increment |
| drop_inc | input | 1 | Dropped-packet counter increment strobe |
| drop_inc_idx | input | 8 | Index of the dropped-packet counter to increment |

## Verification
Random fetches mix both groups with indices inside and beyond each group. Per-port and dropped-packet strobes land on arbitrary edges around each fetch. This separates increments that fall inside the fetch delay, which must be counted, from the one on the capture edge, which must be left out. Directed sequences check the following cases:
- a strobe that coincides with the clearing capture;
- a counter pushed past its wrap point, which shows that the sticky flag is set and then cleared;
- a 16-bit dropped count spanning two result bytes, read twice to show that no clearing happens;
- a function code outside the two valid ones;
- a fetch restarted while pending, which shows the aborted counter survives.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int RESULT_W  = 32;
    localparam int MAX_CNT_W = 30;

    // register window addresses (software decodes these)
    localparam logic [7:0] A_FUNC = 8'd110;
    localparam logic [7:0] A_TRIG = 8'd111;
    localparam logic [7:0] A_RES3 = 8'd117;
    localparam logic [7:0] A_RES2 = 8'd118;
    localparam logic [7:0] A_RES1 = 8'd119;
    localparam logic [7:0] A_RES0 = 8'd120;

    // function codes naming the counter group
    localparam logic [7:0] FN_PORT = 8'h1C;
    localparam logic [7:0] FN_DROP = 8'h1D;

    // result for an index beyond the selected group: valid, no overflow, zero
    localparam logic [RESULT_W-1:0] EMPTY_WORD = 32'h4000_0000;

    typedef enum logic {
        GRP_PORT = 1'b0,
        GRP_DROP = 1'b1
    } grp_e;
endpackage

// File: rtl/stat_regif.sv
module stat_regif
    import stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic [RESULT_W-1:0] snap,
    output logic [7:0]          reg_rdata,
    output logic                start,
    output grp_e                start_grp,
    output logic [7:0]          start_idx
);
    typedef struct packed {
        logic [7:0] func;
        logic [7:0] idx;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we && (reg_addr == A_FUNC)) r_d.func = reg_wdata;
        if (reg_we && (reg_addr == A_TRIG)) r_d.idx  = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // the index write is the trigger, gated by a recognised function code
    assign start     = reg_we && (reg_addr == A_TRIG)
                       && ((r_q.func == FN_PORT) || (r_q.func == FN_DROP));
    assign start_grp = (r_q.func == FN_DROP) ? GRP_DROP : GRP_PORT;
    assign start_idx = reg_wdata;

    always_comb begin
        case (reg_addr)
            A_FUNC:  reg_rdata = r_q.func;
            A_TRIG:  reg_rdata = r_q.idx;
            A_RES3:  reg_rdata = snap[31:24];
            A_RES2:  reg_rdata = snap[23:16];
            A_RES1:  reg_rdata = snap[15:8];
            A_RES0:  reg_rdata = snap[7:0];
            default: reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/stat_read_seq.sv
module stat_read_seq
    import stat_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  grp_e                start_grp,
    input  logic [7:0]          start_idx,
    input  logic [RESULT_W-1:0] rd_word,
    output logic                cap_en,
    output grp_e                cap_grp,
    output logic [7:0]          cap_idx,
    output logic [RESULT_W-1:0] snap
);
    localparam int          LC_W = $clog2(LATENCY + 1);
    localparam logic [LC_W-1:0] LAST = LC_W'(LATENCY - 1);

    typedef struct packed {
        logic                busy;
        logic [LC_W-1:0]     cnt;
        grp_e                grp;
        logic [7:0]          idx;
        logic [RESULT_W-1:0] snap;
    } seq_t;

    seq_t s_d, s_q;

    // a new trigger in the capture cycle wins over the pending capture
    assign cap_en  = s_q.busy && (s_q.cnt == LAST) && !start;
    assign cap_grp = s_q.grp;
    assign cap_idx = s_q.idx;
    assign snap    = s_q.snap;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.grp  = start_grp;
            s_d.idx  = start_idx;
            s_d.snap = '0;
        end else if (cap_en) begin
            s_d.busy = 1'b0;
            s_d.snap = rd_word;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORT_CNT = 160,  // at most 256: indices travel in one byte
    parameter int NUM_DROP_CNT = 8,    // at least 2
    parameter int CNT_W        = 30,   // at most MAX_CNT_W
    parameter int DROP_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_inc,
    input  logic [7:0]          cnt_inc_idx,
    input  logic                drop_inc,
    input  logic [7:0]          drop_inc_idx,
    input  logic                rd_en,
    input  grp_e                rd_grp,
    input  logic [7:0]          rd_idx,
    output logic [RESULT_W-1:0] rd_word
);
    localparam int PI_W = $clog2(NUM_PORT_CNT);
    localparam int DI_W = $clog2(NUM_DROP_CNT);

    logic [CNT_W-1:0]        cnt_q  [NUM_PORT_CNT];
    logic [CNT_W-1:0]        cnt_d  [NUM_PORT_CNT];
    logic [NUM_PORT_CNT-1:0] ovf_q, ovf_d;
    logic [DROP_W-1:0]       drop_q [NUM_DROP_CNT];
    logic [DROP_W-1:0]       drop_d [NUM_DROP_CNT];

    logic            port_inc_ok, drop_inc_ok, port_rd_ok, drop_rd_ok, clr_ok;
    logic [PI_W-1:0] inc_pi, rd_pi;
    logic [DI_W-1:0] inc_di, rd_di;
    logic            carry;
    logic [CNT_W-1:0] nxt;

    assign port_inc_ok = cnt_inc  && ({1'b0, cnt_inc_idx}  < 9'(NUM_PORT_CNT));
    assign drop_inc_ok = drop_inc && ({1'b0, drop_inc_idx} < 9'(NUM_DROP_CNT));
    assign port_rd_ok  = {1'b0, rd_idx} < 9'(NUM_PORT_CNT);
    assign drop_rd_ok  = {1'b0, rd_idx} < 9'(NUM_DROP_CNT);
    assign clr_ok      = rd_en && (rd_grp == GRP_PORT) && port_rd_ok;

    assign inc_pi = cnt_inc_idx[PI_W-1:0];
    assign rd_pi  = rd_idx[PI_W-1:0];
    assign inc_di = drop_inc_idx[DI_W-1:0];
    assign rd_di  = rd_idx[DI_W-1:0];

    always_comb begin
        cnt_d  = cnt_q;
        ovf_d  = ovf_q;
        drop_d = drop_q;
        carry  = 1'b0;
        nxt    = '0;
        // clearing read first, so a same-edge increment lands on zero
        if (clr_ok) begin
            cnt_d[rd_pi] = '0;
            ovf_d[rd_pi] = 1'b0;
        end
        if (port_inc_ok) begin
            {carry, nxt}   = {1'b0, cnt_d[inc_pi]} + (CNT_W + 1)'(1);
            cnt_d[inc_pi]  = nxt;
            if (carry) ovf_d[inc_pi] = 1'b1;
        end
        if (drop_inc_ok) begin
            drop_d[inc_di] = drop_q[inc_di] + DROP_W'(1);
        end
    end

    for (genvar g = 0; g < NUM_PORT_CNT; g++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
                ovf_q[g] <= 1'b0;
            end else begin
                cnt_q[g] <= cnt_d[g];
                ovf_q[g] <= ovf_d[g];
            end
        end
    end

    for (genvar g = 0; g < NUM_DROP_CNT; g++) begin : g_drop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drop_q[g] <= '0;
            else        drop_q[g] <= drop_d[g];
        end
    end

    // word presented to the sequencer; bit 30 marks it as a finished fetch
    always_comb begin
        rd_word = EMPTY_WORD;
        if (rd_grp == GRP_PORT) begin
            if (port_rd_ok)
                rd_word = {ovf_q[rd_pi], 1'b1, MAX_CNT_W'(cnt_q[rd_pi])};
        end else begin
            if (drop_rd_ok)
                rd_word = {2'b01, MAX_CNT_W'(drop_q[rd_di])};
        end
    end
endmodule

// File: rtl/stat_access_unit.sv
module stat_access_unit
    import stat_pkg::*;
#(
    parameter int NUM_PORT_CNT = 160,
    parameter int NUM_DROP_CNT = 8,
    parameter int CNT_W        = 30,
    parameter int DROP_W       = 16,
    parameter int READ_LATENCY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cnt_inc,
    input  logic [7:0] cnt_inc_idx,
    input  logic       drop_inc,
    input  logic [7:0] drop_inc_idx
);
    logic                start_w;
    grp_e                start_grp_w;
    logic [7:0]          start_idx_w;
    logic                cap_en_w;
    grp_e                cap_grp_w;
    logic [7:0]          cap_idx_w;
    logic [RESULT_W-1:0] word_w;
    logic [RESULT_W-1:0] snap_w;

    stat_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .snap      (snap_w),
        .reg_rdata (reg_rdata),
        .start     (start_w),
        .start_grp (start_grp_w),
        .start_idx (start_idx_w)
    );

    stat_read_seq #(
        .LATENCY (READ_LATENCY)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .start_grp (start_grp_w),
        .start_idx (start_idx_w),
        .rd_word   (word_w),
        .cap_en    (cap_en_w),
        .cap_grp   (cap_grp_w),
        .cap_idx   (cap_idx_w),
        .snap      (snap_w)
    );

    stat_counter_bank #(
        .NUM_PORT_CNT (NUM_PORT_CNT),
        .NUM_DROP_CNT (NUM_DROP_CNT),
        .CNT_W        (CNT_W),
        .DROP_W       (DROP_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_inc      (cnt_inc),
        .cnt_inc_idx  (cnt_inc_idx),
        .drop_inc     (drop_inc),
        .drop_inc_idx (drop_inc_idx),
        .rd_en        (cap_en_w),
        .rd_grp       (cap_grp_w),
        .rd_idx       (cap_idx_w),
        .rd_word      (word_w)
    );
endmodule

// File: rtl/stat_access_chk.sv
module stat_access_chk #(
    parameter int LAT = 4,
    parameter int NP  = 160,
    parameter int ND  = 8,
    parameter int DW  = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        cap_en,
    input logic        cap_grp,
    input logic [7:0]  cap_idx,
    input logic [31:0] snap
);
    logic [7:0] age_q;
    logic       armed_q;
    logic       out_of_grp;

    // edges since the most recent trigger, counted independently of the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            age_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            if (age_q != 8'hFF) age_q <= age_q + 1'b1;
            if (cap_en) armed_q <= 1'b0;
        end
    end

    assign out_of_grp = cap_grp ? ({1'b0, cap_idx} >= 9'(ND))
                                : ({1'b0, cap_idx} >= 9'(NP));

    assert_pending_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (snap == 32'h0));

    assert_capture_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (armed_q && (age_q == 8'(LAT - 1))));

    assert_valid_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> snap[30]);

    assert_snapshot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !cap_en) |=> $stable(snap));

    assert_out_of_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && out_of_grp) |=> (snap == 32'h4000_0000));

    assert_drop_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_grp && !out_of_grp) |=> (!snap[31] && ((snap[29:0] >> DW) == 30'h0)));
endmodule

bind stat_access_unit stat_access_chk #(
    .LAT (READ_LATENCY),
    .NP  (NUM_PORT_CNT),
    .ND  (NUM_DROP_CNT),
    .DW  (DROP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_w),
    .cap_en  (cap_en_w),
    .cap_grp (cap_grp_w),
    .cap_idx (cap_idx_w),
    .snap    (snap_w)
);

// File: tb/sim_stat_access_unit.sv
module sim_stat_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 160;
    localparam int ND  = 8;
    localparam int TCW = 8;   // narrow counters so wrap is reachable
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ci = 1'b0;
    logic [7:0] cidx = '0;
    logic       di = 1'b0;
    logic [7:0] didx = '0;

    int checks = 0;
    int failures = 0;

    int unsigned m_cnt [NP];
    bit          m_ovf [NP];
    int unsigned m_drop[ND];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stat_access_unit #(
        .NUM_PORT_CNT (NP),
        .NUM_DROP_CNT (ND),
        .CNT_W        (TCW),
        .DROP_W       (16),
        .READ_LATENCY (LAT)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (we),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .cnt_inc      (ci),
        .cnt_inc_idx  (cidx),
        .drop_inc     (di),
        .drop_inc_idx (didx)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    function automatic void m_port_inc(input int i);
        if (i < NP) begin
            if (m_cnt[i] == (1 << TCW) - 1) begin
                m_cnt[i] = 0;
                m_ovf[i] = 1'b1;
            end else begin
                m_cnt[i]++;
            end
        end
    endfunction

    function automatic logic [31:0] exp_word(input bit grp, input int idx);
        logic [31:0] w;
        w = 32'h4000_0000;
        if (!grp) begin
            if (idx < NP) w = {m_ovf[idx], 1'b1, 30'(m_cnt[idx])};
        end else begin
            if (idx < ND) w = {2'b01, 30'(m_drop[idx])};
        end
        return w;
    endfunction

    // one clock edge with the given inputs; the model follows the sampled strobes
    task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input bit c, input logic [7:0] c_i, input bit dd, input logic [7:0] d_i);
        @(negedge clk);
        we = w; addr = a; wdata = d; ci = c; cidx = c_i; di = dd; didx = d_i;
        @(posedge clk);
        if (c) m_port_inc(int'(c_i));
        if (dd && (int'(d_i) < ND)) m_drop[d_i] = (m_drop[d_i] + 1) & 32'hFFFF;
    endtask

    task automatic rnd_step(input bit w, input logic [7:0] a, input logic [7:0] d);
        bit c, dd;
        logic [7:0] c_i, d_i;
        c   = ($urandom_range(0, 2) == 0);
        c_i = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(160, 255))
                                            : 8'($urandom_range(0, 11));
        dd  = ($urandom_range(0, 3) == 0);
        d_i = 8'($urandom_range(0, 9));
        step(w, a, d, c, c_i, dd, d_i);
    endtask

    task automatic quiet(input bit w, input logic [7:0] a, input logic [7:0] d);
        step(w, a, d, 1'b0, 8'd0, 1'b0, 8'd0);
    endtask

    // reads the four result bytes in the low phase; the next edge sees no stimulus
    task automatic peek(output logic [31:0] res);
        @(negedge clk);
        we = 1'b0; ci = 1'b0; di = 1'b0;
        res = '0;
        for (int b = 0; b < 4; b++) begin
            addr = 8'(117 + b);
            #1;
            res = {res[23:0], rdata};
        end
    endtask

    task automatic peek_reg(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        we = 1'b0; ci = 1'b0; di = 1'b0;
        addr = a;
        #1;
        v = rdata;
    endtask

    // mode 0: random strobes; 1: quiet but a strobe to idx on the capture edge; 2: quiet
    task automatic do_read(input bit grp, input int idx, input int mode, input string req,
                           output logic [31:0] got);
        logic [31:0] expw;
        logic [7:0]  fn;
        fn = grp ? 8'h1D : 8'h1C;
        if (mode == 0) begin
            rnd_step(1'b1, 8'd110, fn);
            rnd_step(1'b1, 8'd111, 8'(idx));
            for (int k = 0; k < LAT - 1; k++) rnd_step(1'b0, 8'd0, 8'd0);
        end else begin
            quiet(1'b1, 8'd110, fn);
            quiet(1'b1, 8'd111, 8'(idx));
            for (int k = 0; k < LAT - 1; k++) quiet(1'b0, 8'd0, 8'd0);
        end
        expw = exp_word(grp, idx);
        if (!grp && idx < NP) begin
            m_cnt[idx] = 0;
            m_ovf[idx] = 1'b0;
        end
        if (mode == 0)      rnd_step(1'b0, 8'd0, 8'd0);
        else if (mode == 1) step(1'b0, 8'd0, 8'd0, 1'b1, 8'(idx), 1'b0, 8'd0);
        else                quiet(1'b0, 8'd0, 8'd0);
        peek(got);
        check(req, got, expw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=00000000 exp=00000001");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  v;
        logic [31:0] snap_keep;
        void'($urandom(32'd2024));
        for (int i = 0; i < NP; i++) begin m_cnt[i] = 0; m_ovf[i] = 1'b0; end
        for (int i = 0; i < ND; i++) m_drop[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(w);              check("R1 result after reset", w, 32'h0);
        peek_reg(8'd110, v);  check("R1 function reg after reset", 32'(v), 32'h0);
        peek_reg(8'd111, v);  check("R1 index reg after reset", 32'(v), 32'h0);
        // R4: unmapped address
        peek_reg(8'd50, v);   check("R4 unmapped address reads zero", 32'(v), 32'h0);

        // R3: fetch delay
        quiet(1'b1, 8'd110, 8'h1C);
        quiet(1'b1, 8'd111, 8'd0);
        for (int k = 0; k < LAT; k++) begin
            peek(w); check("R3 result zero while pending", w, 32'h0);
        end
        peek(w); check("R3 valid after fixed delay", w, 32'h4000_0000);
        peek_reg(8'd111, v); check("R4 index reg readback", 32'(v), 32'h0);

        // R6: strobe on the capture edge
        for (int k = 0; k < 5; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd3, 1'b0, 8'd0);
        do_read(1'b0, 3, 1, "R6 capture-edge strobe excluded", w);
        check("R6 capture-edge strobe excluded literal", w, 32'h4000_0005);
        do_read(1'b0, 3, 2, "R6 counter left at one", w);
        check("R6 counter left at one literal", w, 32'h4000_0001);

        // R7: wrap and sticky flag; R4 byte order of bit 31
        for (int k = 0; k < (1 << TCW) + 4; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd5, 1'b0, 8'd0);
        do_read(1'b0, 5, 2, "R7 overflow flag set", w);
        check("R7 overflow flag set literal", w, 32'hC000_0004);
        do_read(1'b0, 5, 2, "R7 flag cleared by read", w);
        check("R7 flag cleared by read literal", w, 32'h4000_0000);

        // R8: dropped-packet counter spanning two bytes, not cleared
        for (int k = 0; k < 265; k++) step(1'b0, 8'd0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd3);
        do_read(1'b1, 3, 2, "R8 drop counter value", w);
        check("R4 R8 drop counter byte order", w, 32'h4000_0109);
        do_read(1'b1, 3, 2, "R8 drop counter not cleared", w);
        check("R8 drop counter not cleared literal", w, 32'h4000_0109);

        // R9: indices beyond the group; out-of-group strobe ignored
        step(1'b0, 8'd0, 8'd0, 1'b1, 8'd200, 1'b1, 8'd12);
        do_read(1'b0, 200, 2, "R9 port index out of range", w);
        check("R9 port index out of range literal", w, 32'h4000_0000);
        do_read(1'b1, 12, 2, "R9 drop index out of range", w);
        check("R9 drop index out of range literal", w, 32'h4000_0000);

        // R10: snapshot hold
        for (int k = 0; k < 2; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd7, 1'b0, 8'd0);
        do_read(1'b0, 7, 2, "R10 hold setup", w);
        for (int k = 0; k < 3; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd7, 1'b0, 8'd0);
        peek(w); check("R10 snapshot unchanged by increments", w, 32'h4000_0002);

        // R10: restart while pending
        for (int k = 0; k < 3; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd1, 1'b0, 8'd0);
        for (int k = 0; k < 7; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd2, 1'b0, 8'd0);
        quiet(1'b1, 8'd110, 8'h1C);
        quiet(1'b1, 8'd111, 8'd1);
        peek(w); check("R10 pending before restart", w, 32'h0);
        quiet(1'b1, 8'd111, 8'd2);
        for (int k = 0; k < LAT; k++) begin
            peek(w); check("R10 restarted delay", w, 32'h0);
        end
        peek(w); check("R10 restarted fetch result", w, 32'h4000_0007);
        m_cnt[2] = 0; m_ovf[2] = 1'b0;
        do_read(1'b0, 1, 2, "R10 aborted fetch left counter", w);
        check("R10 aborted fetch left counter literal", w, 32'h4000_0003);

        // R2: unrecognised function code ignored
        snap_keep = w;
        for (int k = 0; k < 2; k++) step(1'b0, 8'd0, 8'd0, 1'b1, 8'd4, 1'b0, 8'd0);
        quiet(1'b1, 8'd110, 8'h07);
        quiet(1'b1, 8'd111, 8'd4);
        peek_reg(8'd110, v); check("R4 function reg readback", 32'(v), 32'h07);
        for (int k = 0; k < LAT + 1; k++) peek(w);
        check("R2 unrecognised function leaves result", w, snap_keep);
        do_read(1'b0, 4, 2, "R2 unrecognised function leaves counter", w);
        check("R2 counter untouched literal", w, 32'h4000_0002);

        // R5 R8 R9: random fetches around random strobes
        for (int n = 0; n < 200; n++) begin
            bit    grp;
            int    idx;
            string tag;
            grp = ($urandom_range(0, 3) == 0);
            if (grp) idx = $urandom_range(0, 9);
            else     idx = ($urandom_range(0, 9) == 0) ? $urandom_range(150, 175)
                                                       : $urandom_range(0, 11);
            if (grp) tag = (idx < ND) ? "R8 random drop fetch" : "R9 random drop out of range";
            else     tag = (idx < NP) ? "R5 random port fetch" : "R9 random port out of range";
            do_read(grp, idx, 0, tag, w);
            repeat ($urandom_range(0, 6)) rnd_step(1'b0, 8'd0, 8'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule